// File: doc/BRIEF.md
# Gated Serial-to-Nibble Receiver

This block turns a one-bit serial data line into 4-bit parallel words. Data is sampled on the rising clock edge, and only while a receive-enable input is held high. Each enabled edge captures one bit. The first bit of a group lands in bit 0 and each later bit lands one position higher. When the fourth bit of a group has been captured, the complete word appears on the parallel output and an acknowledge flag pulses for one cycle.

While the enable stays high, the block goes straight on to the next group with no idle cycle in between. Dropping the enable stops reception at once. Any bits already gathered for an unfinished group are discarded, and the last complete word stays on the output. The block has no start bits, stop bits, parity or baud-rate logic. The enable alone decides which clock edges carry data.

Top module: `gated_nibble_rx`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, that edge clears `word_out` to 0, clears `word_ack` to 0 and returns the bit position to the start of a group, whatever `rx_en` and `ser_in` are doing.
- R2: While `rx_en` is low, `ser_in` has no effect: `word_out` holds its value and `word_ack` stays 0.
- R3: Within a group, the bit sampled at the first enabled edge is placed in `word_out[0]`, the second in `word_out[1]`, the third in `word_out[2]` and the fourth in `word_out[3]`.
- R4: `word_ack` is 1 for exactly the one cycle that follows the edge capturing the fourth bit of a group. In that same cycle `word_out` first shows the new word.
- R5: `word_out` changes only at the edge that completes a group. Edges that capture the first, second or third bit leave it unchanged.
- R6: While `rx_en` stays high, groups follow one another with no gap. The edge after a group's fourth bit captures bit 0 of the next group, so `word_ack` pulses once every four cycles.
- R7: If `rx_en` goes low before a group is complete, the partial bits are thrown away. The next enabled edge starts a new group at bit 0.
- R8: A group cut short by `rx_en` going low raises no `word_ack`, even if it was cut short right before its fourth bit.
- R9: A reset in the middle of a group discards the bits gathered so far. After reset is released, counting restarts at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling and state changes happen on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_en | input | 1 | Receive enable; each rising edge with this high captures one bit |
| ser_in | input | 1 | Serial data bit |
| word_out | output | 4 | Last complete parallel word |
| word_ack | output | 1 | One-cycle pulse marking a new word on `word_out` |

## Verification
The main function is driven with words whose bits are deliberately uneven, such as 1101 and 0001. These catch a reversed bit order or a swapped bit position that a symmetric pattern would hide. A run of back-to-back groups with the enable held high separates a gap-free counter wrap from one that stalls for a cycle. Enable drops after two and after three bits are followed by a fresh group. This shows whether leftover bit positions are kept, because a kept count makes the acknowledge arrive early and brings stale bits into the word. A reset in the middle of a group, and a reset asserted while the enable is high, show that reset takes priority over capture and restarts the bit position.

// File: rtl/nrx_pkg.sv
// Package nrx_pkg
// Shared sizing helpers for the gated serial-to-nibble receiver.
// Assumes word widths of two bits or more.
package nrx_pkg;

    // Default number of bits packed into one parallel word
    localparam int unsigned NRX_WORD_W = 4;

    // Width of a counter that indexes every bit of a word
    function automatic int unsigned pos_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/nrx_bit_counter.sv
// Module nrx_bit_counter
// Tracks which bit position of the current group the next enabled edge
// writes. The position returns to zero when the enable is low, and it wraps
// to zero right after the last position, so no cycle is lost between groups.
// Assumes WORD_W >= 2 and a synchronous active-low reset.
module nrx_bit_counter #(
    parameter int unsigned WORD_W = nrx_pkg::NRX_WORD_W,
    localparam int unsigned POS_W = nrx_pkg::pos_width(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    output logic [POS_W-1:0] pos,
    output logic             at_last
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_W - 1);

    // Flags the final bit position of a group
    always_comb at_last = (pos == LAST_POS);

    // Advances the position on enabled edges; clears it on reset, on idle and after the last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (!rx_en || at_last) begin
            pos <= '0;
        end else begin
            pos <= pos + POS_W'(1);
        end
    end

endmodule

// File: rtl/nrx_shift_assembler.sv
// Module nrx_shift_assembler
// Stores each incoming serial bit at the position given by the bit counter.
// Combines the stored bits with the bit arriving now, so that the full word
// is ready on the edge that completes a group.
// Assumes every position is rewritten before a group completes, so bits
// left over from an aborted group never reach the output.
module nrx_shift_assembler #(
    parameter int unsigned WORD_W = nrx_pkg::NRX_WORD_W,
    localparam int unsigned POS_W = nrx_pkg::pos_width(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              ser_in,
    input  logic [POS_W-1:0]  pos,
    output logic [WORD_W-1:0] merged
);

    logic [WORD_W-1:0] stage;

    for (genvar gi = 0; gi < WORD_W; gi++) begin : g_slot
        localparam logic [POS_W-1:0] SLOT = POS_W'(gi);

        // Captures the serial bit into this slot when the counter points at it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage[gi] <= 1'b0;
            end else if (rx_en && (pos == SLOT)) begin
                stage[gi] <= ser_in;
            end
        end

        // Uses the bit arriving now for the current slot and the stored bit for the others
        always_comb merged[gi] = (pos == SLOT) ? ser_in : stage[gi];
    end

endmodule

// File: rtl/nrx_word_reg.sv
// Module nrx_word_reg
// Holds the last complete word and produces the one-cycle acknowledge.
// Loads only on an enabled edge at the last bit position.
// Assumes a synchronous active-low reset.
module nrx_word_reg #(
    parameter int unsigned WORD_W = nrx_pkg::NRX_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              at_last,
    input  logic [WORD_W-1:0] merged,
    output logic [WORD_W-1:0] word_q,
    output logic              ack_q
);

    logic complete;

    // Marks the edge that finishes a group
    always_comb complete = rx_en && at_last;

    // Loads the finished word and raises the acknowledge for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            ack_q  <= 1'b0;
        end else begin
            ack_q <= complete;
            if (complete) begin
                word_q <= merged;
            end
        end
    end

endmodule

// File: rtl/gated_nibble_rx.sv
// Module gated_nibble_rx
// Enable-gated serial-to-parallel receiver. Each rising edge with rx_en high
// captures ser_in. Every WORD_W captures yield one word on word_out and a
// one-cycle word_ack. Dropping rx_en discards any partial group.
// Assumes ser_in and rx_en are synchronous to clk; the reset is synchronous
// and active low.
module gated_nibble_rx #(
    parameter int unsigned WORD_W = nrx_pkg::NRX_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              ser_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_ack
);

    localparam int unsigned POS_W = nrx_pkg::pos_width(WORD_W);

    logic [POS_W-1:0]  pos;
    logic              at_last;
    logic [WORD_W-1:0] merged;

    nrx_bit_counter #(.WORD_W(WORD_W)) counter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_en   (rx_en),
        .pos     (pos),
        .at_last (at_last)
    );

    nrx_shift_assembler #(.WORD_W(WORD_W)) assembler_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_en  (rx_en),
        .ser_in (ser_in),
        .pos    (pos),
        .merged (merged)
    );

    nrx_word_reg #(.WORD_W(WORD_W)) word_reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_en   (rx_en),
        .at_last (at_last),
        .merged  (merged),
        .word_q  (word_out),
        .ack_q   (word_ack)
    );

endmodule

// File: rtl/nrx_checker.sv
// Module nrx_checker
// Port-level properties of gated_nibble_rx, attached to it with bind.
// Assumes the reset is held low for at least one clock edge before use.
module nrx_checker #(
    parameter int unsigned WORD_W = nrx_pkg::NRX_WORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic [WORD_W-1:0] word_out,
    input logic              word_ack
);

    logic armed;
    logic prev_rst_low;

    // Arms history-based checks once two edges have passed with reset released
    always_ff @(posedge clk) begin
        armed        <= rst_n;
        prev_rst_low <= !rst_n;
    end

    // R1: an edge with reset low leaves both outputs cleared
    assert_reset_clears_R1: assert property (@(posedge clk)
        prev_rst_low |-> (word_out == '0 && !word_ack));

    // R4: the acknowledge never lasts two cycles
    assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_ack |=> !word_ack);

    // R5: the word only moves together with an acknowledge
    assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !word_ack |-> $stable(word_out));

    // R8: no acknowledge unless the previous edge was enabled
    assert_ack_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        word_ack |-> $past(rx_en));

endmodule

bind gated_nibble_rx nrx_checker #(.WORD_W(WORD_W)) checker_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .word_out (word_out),
    .word_ack (word_ack)
);

// File: tb/gated_nibble_rx_tb_top.sv
// Bench for gated_nibble_rx: a vector table walked cycle by cycle, then
// directed tests for a reset in the middle of a group and for long
// back-to-back runs.
module gated_nibble_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 4;
    localparam int NVEC       = 29;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              rx_en;
    logic              ser_in;
    logic [WORD_W-1:0] word_out;
    logic              word_ack;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    gated_nibble_rx #(.WORD_W(WORD_W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .ser_in   (ser_in),
        .word_out (word_out),
        .word_ack (word_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector fields: {req[3:0], rst_n, rx_en, ser_in, exp_word[3:0], exp_ack}
    localparam logic [11:0] VECS [NVEC] = '{
        {4'd1, 3'b000, 4'h0, 1'b0},  // R1 reset
        {4'd1, 3'b011, 4'h0, 1'b0},  // R1 reset beats enable
        {4'd2, 3'b101, 4'h0, 1'b0},  // R2 idle, data ignored
        {4'd2, 3'b100, 4'h0, 1'b0},  // R2
        {4'd5, 3'b111, 4'h0, 1'b0},  // R5 bit0=1
        {4'd5, 3'b110, 4'h0, 1'b0},  // R5 bit1=0
        {4'd5, 3'b111, 4'h0, 1'b0},  // R5 bit2=1
        {4'd3, 3'b111, 4'hD, 1'b1},  // R3 R4 bit3=1 -> 1101
        {4'd4, 3'b110, 4'hD, 1'b0},  // R4 pulse ends; next group bit0=0
        {4'd6, 3'b111, 4'hD, 1'b0},  // R6
        {4'd6, 3'b111, 4'hD, 1'b0},  // R6
        {4'd6, 3'b110, 4'h6, 1'b1},  // R6 gap-free group -> 0110
        {4'd5, 3'b111, 4'h6, 1'b0},  // R5 partial
        {4'd5, 3'b111, 4'h6, 1'b0},  // R5 partial
        {4'd7, 3'b101, 4'h6, 1'b0},  // R7 enable drop after two bits
        {4'd2, 3'b100, 4'h6, 1'b0},  // R2
        {4'd7, 3'b110, 4'h6, 1'b0},  // R7 fresh group
        {4'd7, 3'b110, 4'h6, 1'b0},  // R7
        {4'd7, 3'b110, 4'h6, 1'b0},  // R7
        {4'd7, 3'b111, 4'h8, 1'b1},  // R7 -> 1000
        {4'd2, 3'b101, 4'h8, 1'b0},  // R2
        {4'd8, 3'b111, 4'h8, 1'b0},  // R8
        {4'd8, 3'b111, 4'h8, 1'b0},  // R8
        {4'd8, 3'b111, 4'h8, 1'b0},  // R8 three bits
        {4'd8, 3'b101, 4'h8, 1'b0},  // R8 drop in place of fourth bit
        {4'd7, 3'b111, 4'h8, 1'b0},  // R7
        {4'd7, 3'b111, 4'h8, 1'b0},  // R7
        {4'd7, 3'b111, 4'h8, 1'b0},  // R7
        {4'd7, 3'b111, 4'hF, 1'b1}   // R7 -> 1111
    };

    // Drives one cycle of inputs and waits until just after the capturing edge
    task automatic apply(input logic r, input logic e, input logic d);
        rst_n  = r;
        rx_en  = e;
        ser_in = d;
        @(posedge clk);
        #1;
    endtask

    // Compares both outputs with the expected values
    task automatic check(input logic [WORD_W-1:0] ew, input logic ea, input string tag);
        checks++;
        if (word_out !== ew || word_ack !== ea) begin
            failures++;
            $display("FAIL %s: word=%h ack=%b expected word=%h ack=%b",
                     tag, word_out, word_ack, ew, ea);
        end
    endtask

    // Ends a hung run as a failure
    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [WORD_W-1:0] prev;
        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [11:0] v;
            v = VECS[i];
            apply(v[7], v[6], v[5]);
            check(v[4:1], v[0], $sformatf("R%0d vec%0d", v[11:8], i));
        end

        // R1 R9: reset in the middle of a group while enabled
        apply(1'b1, 1'b1, 1'b1);
        check(4'hF, 1'b0, "R9 partial bit");
        apply(1'b1, 1'b1, 1'b1);
        check(4'hF, 1'b0, "R9 partial bit");
        apply(1'b0, 1'b1, 1'b1);
        check(4'h0, 1'b0, "R1 reset clears word");
        apply(1'b1, 1'b1, 1'b0);
        check(4'h0, 1'b0, "R9 restart bit0");
        apply(1'b1, 1'b1, 1'b1);
        check(4'h0, 1'b0, "R9 bit1");
        apply(1'b1, 1'b1, 1'b0);
        check(4'h0, 1'b0, "R9 bit2");
        apply(1'b1, 1'b1, 1'b0);
        check(4'h2, 1'b1, "R9 group from bit0 -> 0010");

        // R6 R3: long back-to-back run with varied words
        prev = 4'h2;
        for (int g = 0; g < 8; g++) begin
            logic [WORD_W-1:0] val;
            val = WORD_W'((g * 5 + 3) & 15);
            for (int b = 0; b < WORD_W; b++) begin
                apply(1'b1, 1'b1, val[b]);
                if (b == WORD_W - 1) begin
                    check(val, 1'b1, "R6 R3 back-to-back word");
                end else begin
                    check(prev, 1'b0, "R6 R5 mid-group");
                end
            end
            prev = val;
        end

        apply(1'b1, 1'b0, 1'b1);
        check(prev, 1'b0, "R2 idle after run");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule